// File: doc/BRIEF.md
# Skin-Gated Horizontal Window Blur

This block is a streaming pixel filter placed in a video path. It takes one RGB pixel per accepted beat and decides whether the pixel looks like skin. For that test it works out each colour component as an integer percentage of the pixel's total brightness. Two trailing windows of equal length slide along the current line. One counts how many recent pixels were skin. The other keeps per-channel running sums of the recent pixel values.

When the skin count in the window is above a threshold, the block sends out the window's average colour. Otherwise it sends the pixel unchanged. A line ends on the beat that carries the last flag. Both windows restart empty after that beat, so a blur never mixes pixels from two lines. The threshold is taken from an input port once, just after reset. The output side follows a valid/ready handshake and holds its data while the downstream side stalls.

Top module: `skin_hblur`

## Requirements
- R1: A pixel is skin only if, with S = R+G+B and each percentage taken as floor(100*C/S), red lies in 35..45, green in 28..36 and blue in 23..31, all bounds inclusive. A pixel with S = 0 is never skin. Pixel data is packed as {R[23:16], G[15:8], B[7:0]}.
- R2: The window covers the WIN (default 16) most recent accepted pixels of the current line, counting the current one. Positions not yet filled in the line count as zero. The blurred value of each channel is the window sum shifted right by log2(WIN).
- R3: The output is blurred exactly when the number of skin pixels in the window is strictly greater than the captured threshold.
- R4: When the output is not blurred, the output data equals the input pixel bit for bit.
- R5: The last flag travels with its pixel to the output. After a beat with the last flag set, both windows restart empty, so the first pixel of the next line sees no earlier pixel.
- R6: Each accepted pixel yields exactly one output beat, in order. m_valid rises in the cycle after acceptance, and drops after a handshake when no new pixel was accepted.
- R7: While m_valid is high and m_ready is low, m_data and m_last hold and s_ready is low.
- R8: The threshold is sampled from thresh_in on the first clock edge after reset is released. s_ready stays low until that edge. Later changes of thresh_in have no effect.
- R9: During reset, m_valid and s_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thresh_in | input | $clog2(WIN)+1 | Skin count threshold, sampled once after reset |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Block can take an input pixel |
| s_data | input | 24 | Input pixel {R,G,B} |
| s_last | input | 1 | Input pixel is the last of its line |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream can take the output pixel |
| m_data | output | 24 | Output pixel {R,G,B} |
| m_last | output | 1 | Output pixel is the last of its line |

## Verification
The bench drives pixels that sit exactly on and just outside the percentage bounds, plus a black pixel. A design with an off-by-one bound or a divide-by-zero fault would blur the wrong pixels or let a zero-sum pixel count as skin. A line longer than the window tests the running sums. A design that never subtracts the leaving pixel would give averages that drift above the real window mean. A short all-skin line right after a skin-rich line checks the clear at line end: if the windows carried over, that line would come out blurred. A pass with stalls and input gaps checks that held outputs do not change, and a threshold change after capture must not switch a lone skin pixel to blurred.

// File: rtl/skin_hblur_pkg.sv
package skin_hblur_pkg;
  localparam int CH_W = 8;
  localparam int PIX_W = 3 * CH_W;
  // percentage bounds: lower inclusive, upper given as (max+1) for a strict compare
  localparam int R_LO = 35;
  localparam int R_HI1 = 46;
  localparam int G_LO = 28;
  localparam int G_HI1 = 37;
  localparam int B_LO = 23;
  localparam int B_HI1 = 32;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/skin_hblur_class.sv
module skin_hblur_class
  import skin_hblur_pkg::*;
(
  input  rgb_t px,
  output logic skin
);
  localparam int SUM_W = CH_W + 2;
  localparam int PW = CH_W + 12;

  logic [SUM_W-1:0] tot;
  logic [PW-1:0] tot_w;
  logic r_ok, g_ok, b_ok;

  // floor(100*c/s) in [lo, hi] is the same as 100*c >= lo*s and 100*c < (hi+1)*s
  function automatic logic band(input logic [CH_W-1:0] c, input logic [PW-1:0] s,
                                input int lo, input int hi1);
    logic [PW-1:0] scaled;
    logic [PW-1:0] lo_lim;
    logic [PW-1:0] hi_lim;
    scaled = PW'(c) * PW'(100);
    lo_lim = s * PW'(lo);
    hi_lim = s * PW'(hi1);
    return (scaled >= lo_lim) && (scaled < hi_lim);
  endfunction

  always_comb begin
    tot   = SUM_W'(px.r) + SUM_W'(px.g) + SUM_W'(px.b);
    tot_w = PW'(tot);
    r_ok  = band(px.r, tot_w, R_LO, R_HI1);
    g_ok  = band(px.g, tot_w, G_LO, G_HI1);
    b_ok  = band(px.b, tot_w, B_LO, B_HI1);
    skin  = (tot != '0) && r_ok && g_ok && b_ok;
  end
endmodule

// File: rtl/skin_hblur_win.sv
module skin_hblur_win #(
  parameter int WIN = 16,
  parameter int DW  = 8,
  parameter int SW  = DW + $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  input  logic [DW-1:0] din,
  output logic [SW-1:0] sum_cur
);
  logic [DW-1:0] tap_q [WIN];
  logic [DW-1:0] tap_d [WIN];
  logic [SW-1:0] sum_q, sum_d;

  // sum including the new sample and excluding the one that leaves
  assign sum_cur = sum_q + SW'(din) - SW'(tap_q[WIN-1]);

  always_comb begin
    sum_d = clr ? '0 : sum_cur;
    for (int i = 0; i < WIN; i++) begin
      if (clr)
        tap_d[i] = '0;
      else if (i == 0)
        tap_d[i] = din;
      else
        tap_d[i] = tap_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      for (int i = 0; i < WIN; i++) tap_q[i] <= '0;
    end else if (adv) begin
      sum_q <= sum_d;
      for (int i = 0; i < WIN; i++) tap_q[i] <= tap_d[i];
    end
  end
endmodule

// File: rtl/skin_hblur.sv
module skin_hblur
  import skin_hblur_pkg::*;
#(
  parameter int WIN = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(WIN):0]     thresh_in,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [PIX_W-1:0]         s_data,
  input  logic                     s_last,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic [PIX_W-1:0]         m_data,
  output logic                     m_last
);
  localparam int LOGW = $clog2(WIN);
  localparam int CW   = LOGW + 1;
  localparam int SW   = CH_W + LOGW;

  rgb_t px, avg_px, out_d, out_q;
  logic skin, adv, blur;
  logic cfg_q, cfg_d;
  logic [CW-1:0] thr_q, thr_d;
  logic ov_q, ov_d;
  logic last_q, last_d;
  logic [CW-1:0] cnt_cur;
  logic [CH_W-1:0] ch_in [3];
  logic [SW-1:0] ch_sum [3];

  assign px      = rgb_t'(s_data);
  assign s_ready = cfg_q && (!ov_q || m_ready);
  assign adv     = s_valid && s_ready;

  skin_hblur_class i_class (.px(px), .skin(skin));

  skin_hblur_win #(.WIN(WIN), .DW(1), .SW(CW)) i_cnt_win (
    .clk(clk), .rst_n(rst_n), .adv(adv), .clr(s_last),
    .din(skin), .sum_cur(cnt_cur)
  );

  assign ch_in[0] = px.r;
  assign ch_in[1] = px.g;
  assign ch_in[2] = px.b;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    skin_hblur_win #(.WIN(WIN), .DW(CH_W), .SW(SW)) i_px_win (
      .clk(clk), .rst_n(rst_n), .adv(adv), .clr(s_last),
      .din(ch_in[c]), .sum_cur(ch_sum[c])
    );
  end

  assign avg_px.r = ch_sum[0][SW-1:LOGW];
  assign avg_px.g = ch_sum[1][SW-1:LOGW];
  assign avg_px.b = ch_sum[2][SW-1:LOGW];
  assign blur     = cnt_cur > thr_q;

  always_comb begin
    cfg_d  = 1'b1;
    thr_d  = cfg_q ? thr_q : thresh_in;
    ov_d   = ov_q;
    out_d  = out_q;
    last_d = last_q;
    if (adv) begin
      ov_d   = 1'b1;
      out_d  = blur ? avg_px : px;
      last_d = s_last;
    end else if (m_ready) begin
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= 1'b0;
      thr_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      thr_q <= thr_d;
      ov_q  <= ov_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      last_q <= 1'b0;
    end else if (adv) begin
      out_q  <= out_d;
      last_q <= last_d;
    end
  end

  assign m_valid = ov_q;
  assign m_data  = out_q;
  assign m_last  = last_q;
endmodule

// File: rtl/skin_hblur_chk.sv
module skin_hblur_chk #(
  parameter int DW = 24,
  parameter int TW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_data,
  input logic          m_last,
  input logic          cfg_q,
  input logic [TW-1:0] thr_q
);
  // R7: stalled output holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  // R7: no input taken while stalled
  a_r7_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  // R6: acceptance produces an output next cycle
  a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);

  // R6: drained output with no new input goes idle
  a_r6_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !(s_valid && s_ready)) |=> !m_valid);

  // R8: threshold frozen after capture
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q |=> (cfg_q && $stable(thr_q)));

  // R8: nothing accepted before capture
  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q |-> !s_ready);
endmodule

bind skin_hblur skin_hblur_chk #(
  .DW(skin_hblur_pkg::PIX_W),
  .TW($clog2(WIN) + 1)
) i_chk (.*);

// File: tb/test_skin_hblur.sv
module test_skin_hblur;
  localparam int WIN = 16;
  localparam int NV  = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] thresh_in;
  logic s_valid, s_ready, s_last;
  logic [23:0] s_data;
  logic m_valid, m_ready, m_last;
  logic [23:0] m_data;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  skin_hblur #(.WIN(WIN)) i_skin_hblur (
    .clk(clk), .rst_n(rst_n), .thresh_in(thresh_in),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  // {last, R, G, B}; three lines of 20, 5 and 7 pixels
  localparam logic [24:0] VEC [NV] = '{
    {1'b0,8'd100,8'd80,8'd70},  {1'b0,8'd120,8'd96,8'd84},  {1'b0,8'd200,8'd50,8'd50},
    {1'b0,8'd110,8'd88,8'd77},  {1'b0,8'd35,8'd36,8'd29},   {1'b0,8'd45,8'd28,8'd27},
    {1'b0,8'd100,8'd80,8'd70},  {1'b0,8'd90,8'd72,8'd63},   {1'b0,8'd0,8'd0,8'd0},
    {1'b0,8'd100,8'd80,8'd70},  {1'b0,8'd130,8'd104,8'd91}, {1'b0,8'd100,8'd80,8'd70},
    {1'b0,8'd100,8'd80,8'd70},  {1'b0,8'd60,8'd50,8'd40},   {1'b0,8'd255,8'd255,8'd255},
    {1'b0,8'd100,8'd80,8'd70},  {1'b0,8'd100,8'd80,8'd70},  {1'b0,8'd10,8'd200,8'd10},
    {1'b0,8'd100,8'd80,8'd70},  {1'b1,8'd100,8'd80,8'd70},
    {1'b0,8'd100,8'd80,8'd70},  {1'b0,8'd100,8'd80,8'd70},  {1'b0,8'd100,8'd80,8'd70},
    {1'b0,8'd100,8'd80,8'd70},  {1'b1,8'd100,8'd80,8'd70},
    {1'b0,8'd34,8'd36,8'd30},   {1'b0,8'd46,8'd28,8'd26},   {1'b0,8'd35,8'd28,8'd23},
    {1'b0,8'd0,8'd0,8'd0},      {1'b0,8'd100,8'd80,8'd70},  {1'b0,8'd100,8'd80,8'd70},
    {1'b1,8'd100,8'd80,8'd70}
  };

  int thr_model = 8;
  int mr [WIN];
  int mg [WIN];
  int mb [WIN];
  int ms [WIN];
  logic [24:0] expq [0:255];
  int qw = 0;
  int qr = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit ref_skin(input int r, input int g, input int b);
    int s;
    int rp, gp, bp;
    s = r + g + b;
    if (s == 0) return 1'b0;
    rp = (100 * r) / s;
    gp = (100 * g) / s;
    bp = (100 * b) / s;
    return (rp >= 35 && rp <= 45) && (gp >= 28 && gp <= 36) && (bp >= 23 && bp <= 31);
  endfunction

  task automatic model_push(input logic [24:0] v);
    int sr, sg, sb, cnt;
    logic [23:0] o;
    for (int i = WIN - 1; i > 0; i--) begin
      mr[i] = mr[i-1]; mg[i] = mg[i-1]; mb[i] = mb[i-1]; ms[i] = ms[i-1];
    end
    mr[0] = int'(v[23:16]);
    mg[0] = int'(v[15:8]);
    mb[0] = int'(v[7:0]);
    ms[0] = int'(ref_skin(mr[0], mg[0], mb[0]));
    sr = 0; sg = 0; sb = 0; cnt = 0;
    for (int i = 0; i < WIN; i++) begin
      sr += mr[i]; sg += mg[i]; sb += mb[i]; cnt += ms[i];
    end
    if (cnt > thr_model)
      o = {8'(sr / WIN), 8'(sg / WIN), 8'(sb / WIN)};
    else
      o = v[23:0];
    expq[qw[7:0]] = {v[24], o};
    qw++;
    if (v[24]) begin
      for (int i = 0; i < WIN; i++) begin
        mr[i] = 0; mg[i] = 0; mb[i] = 0; ms[i] = 0;
      end
    end
  endtask

  task automatic run_table(input bit bp);
    int idx = 0;
    int cyc = 0;
    bit stall_prev = 1'b0;
    logic [24:0] held = '0;
    while ((idx < NV || qr < qw) && cyc < 2000) begin
      @(negedge clk);
      if (stall_prev)
        check(m_valid && ({m_last, m_data} == held), "R7 hold", {7'd0, m_valid, m_last, m_data}, {8'd1, held});
      m_ready = bp ? (cyc % 3 != 0) : 1'b1;
      if (idx < NV && !(bp && (cyc % 5 == 2))) begin
        s_valid = 1'b1;
        s_data  = VEC[idx][23:0];
        s_last  = VEC[idx][24];
      end else begin
        s_valid = 1'b0;
      end
      #1;
      if (m_valid && !m_ready) begin
        check(!s_ready, "R7 ready low", {31'd0, s_ready}, 32'd0);
        stall_prev = 1'b1;
        held = {m_last, m_data};
      end else begin
        stall_prev = 1'b0;
      end
      if (m_valid && m_ready) begin
        check({m_last, m_data} == expq[qr[7:0]], "R1,R2,R3,R4,R5 pixel",
              {7'd0, m_last, m_data}, {7'd0, expq[qr[7:0]]});
        qr++;
      end
      if (s_valid && s_ready) begin
        model_push(VEC[idx]);
        idx++;
      end
      cyc++;
    end
    @(negedge clk);
    s_valid = 1'b0;
    check(qr == qw && idx == NV, "R6 count", qr, qw);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL watchdog expired");
    total++;
    bad++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < WIN; i++) begin
      mr[i] = 0; mg[i] = 0; mb[i] = 0; ms[i] = 0;
    end
    rst_n = 1'b0;
    thresh_in = 5'd8;
    s_valid = 1'b0;
    s_data = '0;
    s_last = 1'b0;
    m_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!m_valid, "R9 m_valid in reset", {31'd0, m_valid}, 32'd0);
    check(!s_ready, "R9 s_ready in reset", {31'd0, s_ready}, 32'd0);

    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!s_ready, "R8 ready before capture", {31'd0, s_ready}, 32'd0);
    @(negedge clk);
    thresh_in = 5'd0;
    #1;
    check(s_ready, "R8 ready after capture", {31'd0, s_ready}, 32'd1);

    // lone skin pixel: threshold 8 passes it, a threshold of 0 would blur it
    s_valid = 1'b1;
    s_data  = {8'd100, 8'd80, 8'd70};
    s_last  = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
    #1;
    check(m_valid, "R6 one-cycle latency", {31'd0, m_valid}, 32'd1);
    check(m_data == {8'd100, 8'd80, 8'd70}, "R8 late threshold ignored", {8'd0, m_data}, {8'd0, 8'd100, 8'd80, 8'd70});
    check(m_last, "R5 last passes", {31'd0, m_last}, 32'd1);
    @(negedge clk);
    #1;
    check(!m_valid, "R6 drain", {31'd0, m_valid}, 32'd0);

    run_table(1'b0);
    run_table(1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule